// File: doc/BRIEF.md
# Video beam position counter

This block keeps the beam position for a tile-based video display processor. It holds an 8-bit horizontal slot counter and a 9-bit vertical line counter. It also keeps a frame counter and gives a one-cycle strobe each time the line changes. One input tick advances the horizontal count by one slot. The master-clock division and the uneven widths of the sync slots are handled outside the block.

Two horizontal widths are supported, a 40-cell mode and a 32-cell mode. In each one the slot count skips a fixed range during horizontal blanking. The line count does not change when the slot count wraps. It changes at a fixed slot in the middle of the count. Once per frame the line count also skips forward over a range. Where that skip happens depends on whether the 60 Hz or the 50 Hz standard is in force.

The standard is sampled only when a new frame begins, so a change in the middle of a frame does not disturb the count. Interrupt logic further down the chain uses the line strobe and the counters.

Top module: `beam_pos_gen`

## Requirements
- R1: With `slot_tick` high, `hslot` goes up by one on each clock and wraps from 255 to 0. With `slot_tick` low, `hslot` keeps its value.
- R2: In 40-cell mode (`wide_mode`=1), a tick from slot 182 gives slot 229 instead of 183.
- R3: In 32-cell mode (`wide_mode`=0), a tick from slot 147 gives slot 233 instead of 148.
- R4: `vline` changes only on a tick that makes `hslot` equal 165 in 40-cell mode or 132 in 32-cell mode. It then goes up by one, modulo 512, so 0x1FF becomes 0. At all other times it holds its value.
- R5: `line_adv` is high for exactly the one clock in which a new `vline` value first appears, and low at every other time.
- R6: While the 60 Hz standard is in force, a line step that would give 0x0EB gives 0x1E5 instead.
- R7: While the 50 Hz standard is in force, a line step that would give 0x103 gives 0x1CA instead.
- R8: `frame_cnt` goes up by one, wrapping, when `vline` steps to the first inactive line plus 8. The first inactive line is 224 under 60 Hz and 240 under 50 Hz, so the trigger lines are 232 and 248.
- R9: `std_50hz` (1 = 50 Hz, 0 = 60 Hz) is taken in only on the line step that gives `vline` = 0. Until then the standard already in force stays in use. After reset the 60 Hz standard is in force.
- R10: While reset is active, and after it is released until the first tick, `hslot`, `vline`, `frame_cnt` and `line_adv` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slot_tick | input | 1 | Advance the slot count by one on this clock |
| wide_mode | input | 1 | 1 = 40-cell mode, 0 = 32-cell mode |
| std_50hz | input | 1 | 1 = 50 Hz standard, 0 = 60 Hz; sampled at the start of a frame |
| hslot | output | 8 | Current horizontal slot |
| vline | output | 9 | Current line |
| frame_cnt | output | FRAME_W | Frame count (8 bits by default) |
| line_adv | output | 1 | One-clock strobe on each line change |

## Verification
The assertions assume that `slot_tick` is never high while the internal reset is held. They also assume that `wide_mode` is steady on the clock when the slot count crosses 182 or 147. The bench drives these inputs only on the falling edge and keeps the tick low for several clocks after reset is released. The stimulus changes `wide_mode` only on fixed blocks of clocks during a random-tick stretch, and the property still covers that case because it samples the mode on the same edge. The 50 Hz request is raised in the middle of a 60 Hz frame so that the delayed take-over can be seen. The run then goes on through a whole 50 Hz frame.

// File: rtl/beam_pkg.sv
package beam_pkg;
  localparam int H_W = 8;
  localparam int V_W = 9;

  localparam logic [H_W-1:0] WIDE_GAP_FROM   = 8'd183;
  localparam logic [H_W-1:0] WIDE_GAP_TO     = 8'd229;
  localparam logic [H_W-1:0] NARROW_GAP_FROM = 8'd148;
  localparam logic [H_W-1:0] NARROW_GAP_TO   = 8'd233;
  localparam logic [H_W-1:0] WIDE_LINE_SLOT  = 8'd165;
  localparam logic [H_W-1:0] NARROW_LINE_SLOT = 8'd132;

  localparam logic [V_W-1:0] S60_GAP_FROM = 9'h0EB;
  localparam logic [V_W-1:0] S60_GAP_TO   = 9'h1E5;
  localparam logic [V_W-1:0] S50_GAP_FROM = 9'h103;
  localparam logic [V_W-1:0] S50_GAP_TO   = 9'h1CA;
  localparam logic [V_W-1:0] S60_INACTIVE = 9'd224;
  localparam logic [V_W-1:0] S50_INACTIVE = 9'd240;
  localparam logic [V_W-1:0] FRAME_OFFSET = 9'd8;
endpackage

// File: rtl/beam_rst_sync.sv
module beam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/beam_hcount.sv
module beam_hcount
  import beam_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wide,
  output logic [H_W-1:0] slot,
  output logic           line_step
);
  logic [H_W-1:0] slot_q, slot_d, slot_inc;

  always_comb begin
    slot_inc  = slot_q + 1'b1;
    slot_d    = slot_q;
    line_step = 1'b0;
    if (tick) begin
      if (wide && slot_inc == WIDE_GAP_FROM)         slot_d = WIDE_GAP_TO;
      else if (!wide && slot_inc == NARROW_GAP_FROM) slot_d = NARROW_GAP_TO;
      else                                           slot_d = slot_inc;
      line_step = wide ? (slot_d == WIDE_LINE_SLOT) : (slot_d == NARROW_LINE_SLOT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot_q <= '0;
    else if (tick) slot_q <= slot_d;
  end

  assign slot = slot_q;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot_q));
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot_q == 8'hFF) |=> slot_q == 8'h00);
  p_skip_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wide && slot_q == 8'd182) |=> slot_q == 8'd229);
  p_skip_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wide && slot_q == 8'd147) |=> slot_q == 8'd233);
endmodule

// File: rtl/beam_vcount.sv
module beam_vcount
  import beam_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               std_req,
  output logic [V_W-1:0]     line,
  output logic [FRAME_W-1:0] frame,
  output logic               adv
);
  localparam logic [V_W-1:0] FRAME_LINE_60 = S60_INACTIVE + FRAME_OFFSET;
  localparam logic [V_W-1:0] FRAME_LINE_50 = S50_INACTIVE + FRAME_OFFSET;

  logic [V_W-1:0]     line_q, line_d, line_inc, frame_line;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic               std_q, std_d, adv_q;

  always_comb begin
    line_inc   = line_q + 1'b1;
    frame_line = std_q ? FRAME_LINE_50 : FRAME_LINE_60;
    if (!std_q && line_inc == S60_GAP_FROM)     line_d = S60_GAP_TO;
    else if (std_q && line_inc == S50_GAP_FROM) line_d = S50_GAP_TO;
    else                                        line_d = line_inc;
    frame_d = (line_d == frame_line) ? frame_q + 1'b1 : frame_q;
    std_d   = (line_d == '0) ? std_req : std_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      frame_q <= '0;
      std_q   <= 1'b0;
      adv_q   <= 1'b0;
    end else begin
      adv_q <= step;
      if (step) begin
        line_q  <= line_d;
        frame_q <= frame_d;
        std_q   <= std_d;
      end
    end
  end

  assign line  = line_q;
  assign frame = frame_q;
  assign adv   = adv_q;

  p_vhold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(line_q));
  p_adv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_q |=> !adv_q);
  p_jump60_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !std_q && line_q == 9'h0EA) |=> line_q == 9'h1E5);
  p_jump50_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && std_q && line_q == 9'h102) |=> line_q == 9'h1CA);
  p_frame_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(frame_q));
  p_std_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && line_q == 9'h1FF) |=> $stable(std_q));
endmodule

// File: rtl/beam_pos_gen.sv
module beam_pos_gen
  import beam_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_tick,
  input  logic               wide_mode,
  input  logic               std_50hz,
  output logic [7:0]         hslot,
  output logic [8:0]         vline,
  output logic [FRAME_W-1:0] frame_cnt,
  output logic               line_adv
);
  logic rst_n_int;
  logic step;

  beam_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  beam_hcount u_h (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (slot_tick),
    .wide      (wide_mode),
    .slot      (hslot),
    .line_step (step)
  );

  beam_vcount #(.FRAME_W(FRAME_W)) u_v (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .step    (step),
    .std_req (std_50hz),
    .line    (vline),
    .frame   (frame_cnt),
    .adv     (line_adv)
  );

  p_adv_on_step_r5: assert property (@(posedge clk) disable iff (!rst_n_int)
    line_adv |-> (hslot == 8'd165 || hslot == 8'd132));
endmodule

// File: tb/beam_pos_gen_tb_top.sv
module beam_pos_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_tick = 1'b0;
  logic       wide_mode = 1'b0;
  logic       std_50hz = 1'b0;
  logic [7:0] hslot;
  logic [8:0] vline;
  logic [7:0] frame_cnt;
  logic       line_adv;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  int mh = 0, mv = 0, mf = 0;
  bit madv = 0, mlat = 0;

  always #5 clk = ~clk;

  beam_pos_gen #(.FRAME_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .wide_mode(wide_mode),
    .std_50hz(std_50hz), .hslot(hslot), .vline(vline), .frame_cnt(frame_cnt),
    .line_adv(line_adv)
  );

  function automatic int next_slot(int h, bit w);
    int n = (h + 1) % 256;
    if (w && n == 183) n = 229;
    if (!w && n == 148) n = 233;
    return n;
  endfunction

  function automatic int next_line(int v, bit lat);
    int n = (v + 1) % 512;
    if (!lat && n == 'h0EB) n = 'h1E5;
    if (lat && n == 'h103) n = 'h1CA;
    return n;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", tag, act, exp, mh, mv);
    end
  endtask

  task automatic step(bit t, bit w, bit s);
    @(negedge clk);
    slot_tick = t; wide_mode = w; std_50hz = s;
    @(posedge clk);
    madv = 0;
    if (t) begin
      mh = next_slot(mh, w);
      if (mh == (w ? 165 : 132)) begin
        madv = 1;
        mv = next_line(mv, mlat);
        if (mv == (mlat ? 248 : 232)) mf = (mf + 1) % 256;
        if (mv == 0) mlat = s;
      end
    end
    #2;
    check("R1 R2 R3 hslot", int'(hslot), mh);
    check("R4 R6 R7 R9 vline", int'(vline), mv);
    check("R8 frame_cnt", int'(frame_cnt), mf);
    check("R5 line_adv", int'(line_adv), int'(madv));
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 195000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    bit w;
    bit seen60, seen50, seen_wrap, seen_frame;
    seed = int'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    check("R10 hslot reset", int'(hslot), 0);
    check("R10 vline reset", int'(vline), 0);
    check("R10 frame reset", int'(frame_cnt), 0);
    check("R10 line_adv reset", int'(line_adv), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0);
    check("R10 hold after release", int'(hslot), 0);
    // R1: idle ticks hold the count
    repeat (3) step(1'b0, 1'b1, 1'b0);
    // random-tick stretch with mode changes
    w = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) w = ($urandom % 2) == 1;
      step(($urandom % 4) != 0, w, 1'b0);
    end
    // full rate, 32-cell mode, 60 Hz until line 0x80
    while (mv != 'h80) step(1'b1, 1'b0, 1'b0);
    // R9: request 50 Hz mid-frame; 60 Hz jump must still apply
    seen60 = 0; seen_wrap = 0;
    while (mv != 'h100) begin
      step(1'b1, 1'b0, 1'b1);
      if (madv && mv == 'h1E5) begin seen60 = 1; check("R6 R9 jump to 0x1E5", int'(vline), 'h1E5); end
      if (madv && mv == 0) seen_wrap = 1;
    end
    check("R6 60Hz jump seen", int'(seen60), 1);
    check("R4 wrap to line 0 seen", int'(seen_wrap), 1);
    // 50 Hz frame now in force
    seen50 = 0; seen_frame = 0;
    while (mv != 'h1D0) begin
      step(1'b1, 1'b0, 1'b0);
      if (madv && mv == 'h1CA) begin seen50 = 1; check("R7 jump to 0x1CA", int'(vline), 'h1CA); end
    end
    check("R7 50Hz jump seen", int'(seen50), 1);
    while (mv != 'h10) begin
      step(1'b1, 1'b0, 1'b0);
      if (madv && mv == 0) check("R9 latch back to 60Hz", int'(frame_cnt), mf);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule